// File: doc/BRIEF.md
# Boot-Time Identity Loader from Serial EEPROM

This block runs once every time reset is released. It acts as the master on a two-wire serial EEPROM bus and reads a short block of bytes starting at word address zero. If the first two bytes carry the expected signature, the identification and power-management fields that follow replace the built-in values of the configuration registers. If the signature is wrong, or the memory does not answer, the built-in values stay in place. When the transfer has finished, the block raises `done_o` and holds it.

The bus clock is the system clock divided by `CLK_DIV`. After `done_o` is high, host software can drive the two bus pins directly through a write strobe. This lets the host program the EEPROM by toggling the lines itself.

Top module: `cfg_rom_loader`

## Requirements
- R1: While reset is held, and after it until the load ends, `done_o` is 0. During reset the registers hold their built-in values: vendor 1438H, device 9777H, and zero for the subsystem vendor, subsystem, capability, next-pointer and both power-control bytes. During reset SCL is high and SDA is released (`sda_oe_o`=0).
- R2: Each load starts with START and the byte A0H (device address 1010000, bit 0 = 0 for write), then the word address 00H, then a repeated START and A1H (the same address, bit 0 = 1 for read). The memory acknowledges each of these bytes.
- R3: The block reads NUM_BYTES (32) data bytes. It acknowledges every byte except the last one, answers the last one with NACK, and then sends STOP. At the cycle where `done_o` rises, SCL is high and SDA is released.
- R4: One bit on the bus takes CLK_DIV+1 system clocks: four quarter phases of CLK_DIV/4 clocks each, plus one hand-off clock. A full load is 30+9*NUM_BYTES bit periods (318 for 32 bytes).
- R5: Loaded bytes are applied only when byte 0 is 55H and byte 1 is AAH. With any other signature, every register keeps its built-in value.
- R6: Bytes 2/3 form the vendor ID, 4/5 the device ID, 6/7 the subsystem vendor ID and 8/9 the subsystem ID. In each pair the first byte is the low byte.
- R7: Byte 0AH loads the capability ID and byte 0BH the next-item pointer. Byte 0EH loads the low power-control byte with bits 1:0 forced to 0 (mask FCH). Byte 0FH loads the high power-control byte with only bits 6:5 kept (mask 60H). All other bytes have no effect.
- R8: If the memory NACKs any of the three header bytes, the block sends STOP, keeps all built-in values and raises `done_o`.
- R9: Once `done_o` is high it stays high until the next reset, and the register outputs stop changing.
- R10: A host write strobe while `done_o` is 0 is ignored. From the first strobe accepted after `done_o`, `scl_o` follows the written SCL bit and SDA is driven low exactly when the written SDA bit is 0. Each new strobe takes effect one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release starts the load |
| sda_i | input | 1 | Sensed level of the SDA line |
| host_wr_i | input | 1 | Host strobe that takes over the pins |
| host_sda_i | input | 1 | Host SDA value (1 = release) |
| host_scl_i | input | 1 | Host SCL value |
| scl_o | output | 1 | Serial clock |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| vendor_id_o | output | 16 | Vendor identifier |
| device_id_o | output | 16 | Device identifier |
| subsys_vendor_o | output | 16 | Subsystem vendor identifier |
| subsys_id_o | output | 16 | Subsystem identifier |
| cap_id_o | output | 8 | Capability identifier |
| cap_next_o | output | 8 | Next-item pointer |
| pm_ctl_lo_o | output | 8 | Low power-control byte (bits 7:2) |
| pm_ctl_hi_o | output | 8 | High power-control byte (bits 6:5) |
| done_o | output | 1 | Load finished (sticky) |

## Verification
A bus-level memory model answers the loader and checks the header bytes against a queue of expected bytes. It also counts the master's ACKs, its NACKs, and its STARTs and STOPs. A design that left out the repeated START, or acknowledged the last byte, would show up in these counts. A wrong signature byte checks that no field leaks through, and a memory that stays silent checks the early abort path. One image has all bits set in bytes 0EH/0FH to catch missing masks, and one host strobe is issued in the middle of a load to catch an override that is accepted too early.

// File: rtl/cfg_ld_pkg.sv
package cfg_ld_pkg;
  typedef enum logic [1:0] {SYM_START, SYM_STOP, SYM_BIT} sym_e;
  typedef enum logic [2:0] {S_START, S_TX, S_TACK, S_RX, S_MACK, S_STOP, S_DONE} seq_e;

  localparam logic [15:0] VENDOR_DEF = 16'h1438;
  localparam logic [15:0] DEVICE_DEF = 16'h9777;
  localparam logic [7:0]  SIG_LO     = 8'h55;
  localparam logic [7:0]  SIG_HI     = 8'hAA;
  localparam logic [7:0]  PM_LO_MASK = 8'hFC;
  localparam logic [7:0]  PM_HI_MASK = 8'h60;
endpackage

// File: rtl/cfg_ld_tick.sv
module cfg_ld_tick #(
  parameter int QTR = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == CW'(QTR - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/cfg_ld_phy.sv
module cfg_ld_phy
  import cfg_ld_pkg::*;
#(
  parameter int QTR = 256
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_i,
  input  sym_e sym_i,
  input  logic bit_i,
  input  logic sda_i,
  output logic busy_o,
  output logic fin_o,
  output logic rx_o,
  output logic scl_o,
  output logic sda_lo_o
);
  logic       active_q, tick;
  logic [1:0] phase_q;
  sym_e       sym_q;
  logic       bit_q;
  logic       pat_scl, pat_sda;

  cfg_ld_tick #(.QTR(QTR)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (active_q),
    .tick_o(tick)
  );

  // line levels per quarter: scl high, sda released
  always_comb begin
    pat_scl = 1'b1;
    pat_sda = 1'b1;
    unique case (sym_q)
      SYM_START: begin
        pat_scl = (phase_q == 2'd1) || (phase_q == 2'd2);
        pat_sda = (phase_q <= 2'd1);
      end
      SYM_STOP: begin
        pat_scl = (phase_q != 2'd0);
        pat_sda = (phase_q >= 2'd2);
      end
      default: begin
        pat_scl = (phase_q == 2'd1) || (phase_q == 2'd2);
        pat_sda = bit_q;
      end
    endcase
  end

  assign busy_o   = active_q;
  assign fin_o    = active_q && tick && (phase_q == 2'd3);
  assign scl_o    = pat_q_scl;
  assign sda_lo_o = pat_q_lo;

  logic pat_q_scl, pat_q_lo;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q  <= 1'b0;
      phase_q   <= 2'd0;
      sym_q     <= SYM_STOP;
      bit_q     <= 1'b1;
      rx_o      <= 1'b1;
      pat_q_scl <= 1'b1;
      pat_q_lo  <= 1'b0;
    end else begin
      if (go_i && !active_q) begin
        active_q <= 1'b1;
        phase_q  <= 2'd0;
        sym_q    <= sym_i;
        bit_q    <= bit_i;
      end else if (active_q && tick) begin
        phase_q <= phase_q + 2'd1;
        if (phase_q == 2'd3) active_q <= 1'b0;
        if (phase_q == 2'd1 && sym_q == SYM_BIT) rx_o <= sda_i;
      end
      // hold the lines between symbols
      if (active_q) begin
        pat_q_scl <= pat_scl;
        pat_q_lo  <= !pat_sda;
      end
    end
  end
endmodule

// File: rtl/cfg_ld_seq.sv
module cfg_ld_seq
  import cfg_ld_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter logic [7:0] WORD_ADDR = 8'h00,
  parameter int         NUM_BYTES = 32,
  localparam int        BYTE_W    = $clog2(NUM_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              fin_i,
  input  logic              rx_i,
  output logic              go_o,
  output sym_e              sym_o,
  output logic              bit_o,
  output logic              byte_vld_o,
  output logic [BYTE_W-1:0] byte_idx_o,
  output logic [7:0]        byte_o,
  output logic              done_o
);
  seq_e              st_q;
  logic [1:0]        stage_q;
  logic [7:0]        sh_q;
  logic [2:0]        bitc_q;
  logic [BYTE_W-1:0] bcnt_q;
  logic              last_byte;

  assign last_byte  = (bcnt_q == BYTE_W'(NUM_BYTES - 1));
  assign go_o       = (st_q != S_DONE) && !busy_i;
  assign done_o     = (st_q == S_DONE);
  assign byte_idx_o = bcnt_q;

  always_comb begin
    sym_o = SYM_BIT;
    bit_o = 1'b1;
    unique case (st_q)
      S_START: sym_o = SYM_START;
      S_STOP:  sym_o = SYM_STOP;
      S_TX:    bit_o = sh_q[7];
      S_MACK:  bit_o = last_byte;
      default: bit_o = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= S_START;
      stage_q    <= 2'd0;
      sh_q       <= '0;
      bitc_q     <= '0;
      bcnt_q     <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      byte_vld_o <= 1'b0;
      if (fin_i) begin
        unique case (st_q)
          S_START: begin
            sh_q   <= {DEV_ADDR, stage_q == 2'd2};
            bitc_q <= '0;
            st_q   <= S_TX;
          end
          S_TX: begin
            sh_q   <= {sh_q[6:0], 1'b0};
            bitc_q <= bitc_q + 3'd1;
            if (bitc_q == 3'd7) st_q <= S_TACK;
          end
          S_TACK: begin
            if (rx_i) st_q <= S_STOP;   // header NACK: abort
            else begin
              unique case (stage_q)
                2'd0: begin
                  stage_q <= 2'd1;
                  sh_q    <= WORD_ADDR;
                  bitc_q  <= '0;
                  st_q    <= S_TX;
                end
                2'd1: begin
                  stage_q <= 2'd2;
                  st_q    <= S_START;
                end
                default: begin
                  bitc_q <= '0;
                  bcnt_q <= '0;
                  st_q   <= S_RX;
                end
              endcase
            end
          end
          S_RX: begin
            sh_q   <= {sh_q[6:0], rx_i};
            bitc_q <= bitc_q + 3'd1;
            if (bitc_q == 3'd7) begin
              byte_vld_o <= 1'b1;
              byte_o     <= {sh_q[6:0], rx_i};
              st_q       <= S_MACK;
            end
          end
          S_MACK: begin
            if (last_byte) st_q <= S_STOP;
            else begin
              bcnt_q <= bcnt_q + 1'b1;
              bitc_q <= '0;
              st_q   <= S_RX;
            end
          end
          S_STOP:  st_q <= S_DONE;
          default: st_q <= S_DONE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_ld_regs.sv
module cfg_ld_regs
  import cfg_ld_pkg::*;
#(
  parameter int BYTE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [BYTE_W-1:0] idx_i,
  input  logic [7:0]        data_i,
  output logic [15:0]       vendor_id_o,
  output logic [15:0]       device_id_o,
  output logic [15:0]       subsys_vendor_o,
  output logic [15:0]       subsys_id_o,
  output logic [7:0]        cap_id_o,
  output logic [7:0]        cap_next_o,
  output logic [7:0]        pm_ctl_lo_o,
  output logic [7:0]        pm_ctl_hi_o
);
  logic       sig_lo_q, sig_hi_q;
  logic [7:0] idx8;

  assign idx8 = 8'(idx_i);

  // signature bytes arrive first, so later bytes are gated in place
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sig_lo_q        <= 1'b0;
      sig_hi_q        <= 1'b0;
      vendor_id_o     <= VENDOR_DEF;
      device_id_o     <= DEVICE_DEF;
      subsys_vendor_o <= '0;
      subsys_id_o     <= '0;
      cap_id_o        <= '0;
      cap_next_o      <= '0;
      pm_ctl_lo_o     <= '0;
      pm_ctl_hi_o     <= '0;
    end else if (vld_i) begin
      if (idx8 == 8'h00) sig_lo_q <= (data_i == SIG_LO);
      if (idx8 == 8'h01) sig_hi_q <= (data_i == SIG_HI);
      if (sig_lo_q && sig_hi_q) begin
        unique case (idx8)
          8'h02: vendor_id_o[7:0]      <= data_i;
          8'h03: vendor_id_o[15:8]     <= data_i;
          8'h04: device_id_o[7:0]      <= data_i;
          8'h05: device_id_o[15:8]     <= data_i;
          8'h06: subsys_vendor_o[7:0]  <= data_i;
          8'h07: subsys_vendor_o[15:8] <= data_i;
          8'h08: subsys_id_o[7:0]      <= data_i;
          8'h09: subsys_id_o[15:8]     <= data_i;
          8'h0A: cap_id_o              <= data_i;
          8'h0B: cap_next_o            <= data_i;
          8'h0E: pm_ctl_lo_o           <= data_i & PM_LO_MASK;
          8'h0F: pm_ctl_hi_o           <= data_i & PM_HI_MASK;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_rom_loader.sv
module cfg_rom_loader
  import cfg_ld_pkg::*;
#(
  parameter int         CLK_DIV   = 1024,
  parameter int         NUM_BYTES = 32,
  parameter logic [6:0] DEV_ADDR  = 7'h50,
  parameter logic [7:0] WORD_ADDR = 8'h00
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sda_i,
  input  logic        host_wr_i,
  input  logic        host_sda_i,
  input  logic        host_scl_i,
  output logic        scl_o,
  output logic        sda_oe_o,
  output logic [15:0] vendor_id_o,
  output logic [15:0] device_id_o,
  output logic [15:0] subsys_vendor_o,
  output logic [15:0] subsys_id_o,
  output logic [7:0]  cap_id_o,
  output logic [7:0]  cap_next_o,
  output logic [7:0]  pm_ctl_lo_o,
  output logic [7:0]  pm_ctl_hi_o,
  output logic        done_o
);
  localparam int QTR    = CLK_DIV / 4;
  localparam int BYTE_W = $clog2(NUM_BYTES);

  logic              go, busy, fin, rx, bit_v;
  sym_e              sym;
  logic              phy_scl, phy_sda_lo;
  logic              byte_vld;
  logic [BYTE_W-1:0] byte_idx;
  logic [7:0]        byte_d;
  logic              host_own_q, host_scl_q, host_sda_q;

  cfg_ld_phy #(.QTR(QTR)) u_phy (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (go),
    .sym_i   (sym),
    .bit_i   (bit_v),
    .sda_i   (sda_i),
    .busy_o  (busy),
    .fin_o   (fin),
    .rx_o    (rx),
    .scl_o   (phy_scl),
    .sda_lo_o(phy_sda_lo)
  );

  cfg_ld_seq #(
    .DEV_ADDR (DEV_ADDR),
    .WORD_ADDR(WORD_ADDR),
    .NUM_BYTES(NUM_BYTES)
  ) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy),
    .fin_i     (fin),
    .rx_i      (rx),
    .go_o      (go),
    .sym_o     (sym),
    .bit_o     (bit_v),
    .byte_vld_o(byte_vld),
    .byte_idx_o(byte_idx),
    .byte_o    (byte_d),
    .done_o    (done_o)
  );

  cfg_ld_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .vld_i          (byte_vld),
    .idx_i          (byte_idx),
    .data_i         (byte_d),
    .vendor_id_o    (vendor_id_o),
    .device_id_o    (device_id_o),
    .subsys_vendor_o(subsys_vendor_o),
    .subsys_id_o    (subsys_id_o),
    .cap_id_o       (cap_id_o),
    .cap_next_o     (cap_next_o),
    .pm_ctl_lo_o    (pm_ctl_lo_o),
    .pm_ctl_hi_o    (pm_ctl_hi_o)
  );

  // host pin override, accepted only after the load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_own_q <= 1'b0;
      host_scl_q <= 1'b1;
      host_sda_q <= 1'b1;
    end else if (host_wr_i && done_o) begin
      host_own_q <= 1'b1;
      host_scl_q <= host_scl_i;
      host_sda_q <= host_sda_i;
    end
  end

  assign scl_o    = host_own_q ? host_scl_q : phy_scl;
  assign sda_oe_o = host_own_q ? !host_sda_q : phy_sda_lo;
endmodule

// File: rtl/cfg_rom_loader_chk.sv
module cfg_rom_loader_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        host_wr_i,
  input logic        host_sda_i,
  input logic        host_scl_i,
  input logic        scl_o,
  input logic        sda_oe_o,
  input logic [15:0] vendor_id_o,
  input logic [15:0] device_id_o,
  input logic [7:0]  pm_ctl_lo_o,
  input logic [7:0]  pm_ctl_hi_o,
  input logic        done_o
);
  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  // R9
  ids_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> ($stable(vendor_id_o) && $stable(device_id_o)));

  // R3
  bus_idle_at_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (scl_o && !sda_oe_o));

  // R10
  host_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && host_wr_i) |=> (scl_o == $past(host_scl_i) && sda_oe_o == !$past(host_sda_i)));

  // R7
  pm_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pm_ctl_lo_o[1:0] == 2'b00) && ((pm_ctl_hi_o & 8'h9F) == 8'h00));
endmodule

bind cfg_rom_loader cfg_rom_loader_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .host_wr_i  (host_wr_i),
  .host_sda_i (host_sda_i),
  .host_scl_i (host_scl_i),
  .scl_o      (scl_o),
  .sda_oe_o   (sda_oe_o),
  .vendor_id_o(vendor_id_o),
  .device_id_o(device_id_o),
  .pm_ctl_lo_o(pm_ctl_lo_o),
  .pm_ctl_hi_o(pm_ctl_hi_o),
  .done_o     (done_o)
);

// File: tb/cfg_rom_loader_test.sv
module cfg_rom_loader_test;
  localparam int DIV = 16;
  localparam int NB  = 32;
  localparam int LOAD_CYC = (30 + 9 * NB) * (DIV + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic host_wr = 1'b0, host_sda = 1'b1, host_scl = 1'b1;
  logic scl, sda_oe, done;
  logic [15:0] ven, dev, sven, sid;
  logic [7:0]  capid, capnx, pmlo, pmhi;
  logic slv_low = 1'b0;
  logic sda_line;
  assign sda_line = !(sda_oe || slv_low);

  cfg_rom_loader #(.CLK_DIV(DIV), .NUM_BYTES(NB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sda_i(sda_line),
    .host_wr_i(host_wr), .host_sda_i(host_sda), .host_scl_i(host_scl),
    .scl_o(scl), .sda_oe_o(sda_oe),
    .vendor_id_o(ven), .device_id_o(dev), .subsys_vendor_o(sven), .subsys_id_o(sid),
    .cap_id_o(capid), .cap_next_o(capnx), .pm_ctl_lo_o(pmlo), .pm_ctl_hi_o(pmhi),
    .done_o(done)
  );

  int checks = 0, errors = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // ---- memory model with scoreboard on the header bytes ----
  logic [7:0] mem [NB];
  logic [7:0] exp_q [$];
  bit   respond = 1'b1;
  int   starts, stops, acks, nacks, st, bitn, hdr, last_rise, period;
  bit   p_scl = 1'b1, p_sda = 1'b1, ackd, rw;
  logic [7:0] sh, cur;
  logic [4:0] ptr, waddr;
  int   cyc = 0;

  localparam int IDLE = 0, RXB = 1, ACK1 = 2, ACK2 = 3, TXB = 4, MACK = 5, LOAD = 6;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      st = IDLE; slv_low <= 1'b0; p_scl = 1'b1; p_sda = 1'b1;
    end else begin
      if (p_scl && scl && p_sda && !sda_line) begin
        starts++; st = RXB; bitn = 0; slv_low <= 1'b0;
        if (hdr != 2) hdr = 0;
        else hdr = 3;
      end else if (p_scl && scl && !p_sda && sda_line) begin
        stops++; st = IDLE;
      end else if (!p_scl && scl) begin
        if (last_rise > 0) period = cyc - last_rise;
        last_rise = cyc;
        case (st)
          RXB: begin
            sh = {sh[6:0], sda_line}; bitn++;
            if (bitn == 8) begin
              if (exp_q.size() > 0) begin
                chk(sh == exp_q[0], "R2", "header byte", sh, exp_q[0]);
                void'(exp_q.pop_front());
              end else chk(1'b0, "R2", "unexpected master byte", sh, 0);
              if (hdr == 0 || hdr == 3) begin
                rw = sh[0]; ackd = respond && (sh[7:1] == 7'h50); hdr = 1;
              end else begin
                waddr = sh[4:0]; ackd = 1'b1; hdr = 2;
              end
              st = ACK1;
            end
          end
          TXB: bitn++;
          MACK: begin
            if (!sda_line) begin acks++; ptr++; cur = mem[ptr]; st = LOAD; end
            else begin nacks++; st = IDLE; end
          end
          default: ;
        endcase
      end else if (p_scl && !scl) begin
        case (st)
          ACK1: begin slv_low <= ackd; st = ACK2; end
          ACK2: begin
            slv_low <= 1'b0;
            if (!ackd) st = IDLE;
            else if (hdr == 1 && rw) begin
              cur = mem[ptr]; slv_low <= !cur[7]; bitn = 0; st = TXB;
            end else begin
              st = RXB; bitn = 0;
              if (hdr == 2) ptr = waddr;
            end
          end
          TXB: begin
            if (bitn < 8) slv_low <= !cur[7-bitn];
            else begin slv_low <= 1'b0; st = MACK; end
          end
          LOAD: begin slv_low <= !cur[7]; bitn = 0; st = TXB; end
          default: ;
        endcase
      end
      p_scl = scl; p_sda = sda_line;
    end
  end

  // driver: pushes the expected header for one load
  task automatic push_header(input bit full);
    exp_q.delete();
    exp_q.push_back(8'hA0);
    if (full) begin
      exp_q.push_back(8'h00);
      exp_q.push_back(8'hA1);
    end
  endtask

  task automatic check_defaults(input string req);
    chk(ven == 16'h1438, req, "vendor", ven, 16'h1438);
    chk(dev == 16'h9777, req, "device", dev, 16'h9777);
    chk(sven == 0 && sid == 0, req, "subsystem ids", {sven, sid}, 0);
    chk(capid == 0 && capnx == 0 && pmlo == 0 && pmhi == 0, req, "cap/pm",
        {capid, capnx, pmlo, pmhi}, 0);
  endtask

  int load_cyc;

  task automatic run_load(input bit resp, input bit poke_host);
    respond = resp;
    push_header(resp);
    starts = 0; stops = 0; acks = 0; nacks = 0; hdr = 0; last_rise = 0; period = 0;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!done, "R1", "done in reset", done, 0);
    chk(scl && !sda_oe, "R1", "pins in reset", {scl, sda_oe}, 2'b10);
    check_defaults("R1");
    rst_n = 1'b1;
    load_cyc = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      load_cyc++;
      if (poke_host && i == 1000) begin host_wr = 1'b1; host_scl = 1'b0; host_sda = 1'b0; end
      else host_wr = 1'b0;
      if (done) break;
    end
    host_wr = 1'b0; host_scl = 1'b1; host_sda = 1'b1;
    chk(done, "R1", "load finished", done, 1);
    chk(scl && !sda_oe, "R3", "bus idle at done", {scl, sda_oe}, 2'b10);
    repeat (4) @(negedge clk);
  endtask

  task automatic fill(input logic [7:0] s1);
    for (int i = 0; i < NB; i++) mem[i] = 8'(8'h40 + i);
    mem[0] = 8'h55; mem[1] = s1;
    mem[2] = 8'h34; mem[3] = 8'h12; mem[4] = 8'h78; mem[5] = 8'h56;
    mem[6] = 8'hBC; mem[7] = 8'h9A; mem[8] = 8'hF0; mem[9] = 8'hDE;
    mem[10] = 8'h11; mem[11] = 8'h22; mem[12] = 8'h99; mem[13] = 8'h88;
    mem[14] = 8'hFF; mem[15] = 8'hFF; mem[NB-1] = 8'h00;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // valid image, with an early host strobe that must be ignored (R10)
    fill(8'hAA);
    run_load(1'b1, 1'b1);
    chk(exp_q.size() == 0, "R2", "header bytes left", exp_q.size(), 0);
    chk(starts == 2, "R2", "START count", starts, 2);
    chk(acks == NB - 1, "R3", "master ACKs", acks, NB - 1);
    chk(nacks == 1, "R3", "master NACKs", nacks, 1);
    chk(stops == 1, "R3", "STOP count", stops, 1);
    chk(period == DIV + 1, "R4", "bit period", period, DIV + 1);
    chk(load_cyc >= LOAD_CYC - 2 && load_cyc <= LOAD_CYC + 4, "R4", "load length",
        load_cyc, LOAD_CYC);
    chk(ven == 16'h1234, "R6", "vendor", ven, 16'h1234);
    chk(dev == 16'h5678, "R6", "device", dev, 16'h5678);
    chk(sven == 16'h9ABC, "R6", "subsys vendor", sven, 16'h9ABC);
    chk(sid == 16'hDEF0, "R6", "subsys id", sid, 16'hDEF0);
    chk(capid == 8'h11 && capnx == 8'h22, "R7", "cap bytes", {capid, capnx}, 16'h1122);
    chk(pmlo == 8'hFC, "R7", "pm low mask", pmlo, 8'hFC);
    chk(pmhi == 8'h60, "R7", "pm high mask", pmhi, 8'h60);
    chk(scl && !sda_oe, "R10", "early host strobe ignored", {scl, sda_oe}, 2'b10);
    repeat (100) @(negedge clk);
    chk(done && ven == 16'h1234, "R9", "done/values held", {done, ven}, {1'b1, 16'h1234});
    // host takes the pins
    host_wr = 1'b1; host_scl = 1'b0; host_sda = 1'b1;
    @(negedge clk); host_wr = 1'b0;
    chk(!scl && !sda_oe, "R10", "host scl0 sda1", {scl, sda_oe}, 2'b00);
    host_wr = 1'b1; host_scl = 1'b1; host_sda = 1'b0;
    @(negedge clk); host_wr = 1'b0;
    chk(scl && sda_oe, "R10", "host scl1 sda0", {scl, sda_oe}, 2'b11);

    // bad signature keeps defaults
    fill(8'hAB);
    run_load(1'b1, 1'b0);
    check_defaults("R5");
    chk(acks == NB - 1, "R5", "full read still done", acks, NB - 1);

    // silent memory aborts early
    fill(8'hAA);
    run_load(1'b0, 1'b0);
    check_defaults("R8");
    chk(load_cyc < 30 * (DIV + 1), "R8", "abort early", load_cyc, 30 * (DIV + 1));
    chk(starts == 1 && stops == 1, "R8", "START/STOP on abort", {starts[15:0], stops[15:0]},
        32'h0001_0001);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule